// File: doc/BRIEF.md
# Event Packet Timestamp Capture Latch

This block samples a free-running system time value when a precision-time event frame starts on either the transmit or the receive path. It holds that sample until software collects it. Each direction has its own single-entry latch. The latch takes a sample only when a start-of-frame strobe arrives together with its qualifier. On transmit the qualifier is the per-frame "stamp this frame" mark. On receive it is a classifier flag that is high for every version-2 event message, carried over either layer 2 or layer 4, and path-delay messages count as event messages. Header parsing happens upstream.

A full latch refuses further samples. Each qualified strobe that arrives while the latch is full increments a saturating missed-event counter, and the held value stays unchanged. Software polls the valid flag and releases the latch by reading the high word of the stamp. Descriptor completion gives no hint that a sample was taken, so polling is the only way to know.

A receive frame that was sampled and then dropped would leave the receive latch full for good. A watchdog covers this case: when the receive latch has been full for a programmed number of cycles, the block empties it and flags the lost sample. A software clear empties both latches and zeroes both counters.

Each latch is a two-state machine:
- EMPTY goes to FULL on a qualified strobe, called "take".
- FULL goes to EMPTY on one of three transitions, in this priority: clear, release (high-word read), expire (receive watchdog).
- Clear has priority over take in EMPTY.

Top module: `ptp_ts_latch`

## Requirements
- R1: After reset both valid flags are 0, both stamps are 0, both missed counters are 0 and rx_lost is 0.
- R2: A start strobe with its qualifier high, while that latch is EMPTY and sw_clr is low, stores the sys_time value of that same cycle. The matching valid flag and stamp are visible one cycle later.
- R3: A start strobe with its qualifier low (tx_mark or rx_v2evt equal to 0) neither captures nor counts as missed.
- R4: While a latch is FULL, each qualified strobe leaves the stamp unchanged and adds 1 to that side's missed counter. The counter holds at 2^MISS_W-1 (15 by default).
- R5: A high-word read strobe on a FULL latch clears its valid flag on the next cycle, after which a new capture is accepted. A read strobe on an EMPTY latch has no effect.
- R6: With rx_tmo_limit = L and L not 0, a receive latch left unread shows rx_valid high for exactly L cycles. It is then emptied, and rx_lost is high for one cycle, in the same cycle that rx_valid first reads 0. L = 0 disables the watchdog.
- R7: The transmit latch is never emptied by the watchdog, whatever rx_tmo_limit holds.
- R8: sw_clr empties both latches and zeroes both missed counters on the next cycle. It takes priority over a capture, a read or an expiry in the same cycle.
- R9: The two directions are independent: strobes, reads and misses on one side leave the other side's valid flag, stamp and counter untouched.
- R10: A read strobe in the same cycle the watchdog would expire counts as a release, and rx_lost stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | TIME_W | Current system time |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Transmit frame is marked for stamping |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_v2evt | input | 1 | Receive frame is a version-2 event message |
| tx_rd_hi | input | 1 | Software reads the transmit stamp high word (release) |
| rx_rd_hi | input | 1 | Software reads the receive stamp high word (release) |
| sw_clr | input | 1 | Software clear of both latches and counters |
| rx_tmo_limit | input | TMO_W | Receive watchdog limit in cycles, 0 disables it |
| tx_valid | output | 1 | Transmit latch holds a stamp |
| tx_stamp | output | TIME_W | Held transmit stamp |
| rx_valid | output | 1 | Receive latch holds a stamp |
| rx_stamp | output | TIME_W | Held receive stamp |
| rx_lost | output | 1 | One-cycle pulse: receive stamp discarded by the watchdog |
| tx_miss_cnt | output | MISS_W | Transmit missed-event count, saturating |
| rx_miss_cnt | output | MISS_W | Receive missed-event count, saturating |

## Verification
Every result of this block appears one clock after the edge that samples its stimulus. This covers the valid flags, the stamps, the missed counters and the watchdog's lost pulse, because each is a single register stage. For every stimulus cycle the bench computes the expected next state with its own model of the requirements and queues it. A monitor takes that entry 1 ns after the following rising edge and compares it with all outputs. For the watchdog this means rx_valid is expected high on exactly L consecutive samples, and rx_lost is expected on the first sample where rx_valid is low.

// File: rtl/tsl_pkg.sv
`timescale 1ns/1ps
package tsl_pkg;
    typedef enum logic {
        TSL_EMPTY = 1'b0,
        TSL_FULL  = 1'b1
    } tsl_state_e;
endpackage

// File: rtl/tsl_miss_ctr.sv
`timescale 1ns/1ps
module tsl_miss_ctr #(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bump,
    output logic [MISS_W-1:0] cnt
);
    localparam logic [MISS_W-1:0] CNT_TOP = {MISS_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (bump && cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsl_age_timer.sv
`timescale 1ns/1ps
module tsl_age_timer #(
    parameter int TMO_W   = 16,
    parameter bit HAS_TMO = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    localparam logic [TMO_W-1:0] ONE = {{(TMO_W-1){1'b0}}, 1'b1};

    logic [TMO_W-1:0] age;

    // Age counts cycles spent FULL; it restarts whenever the latch is empty.
    assign expire = HAS_TMO && run && (limit != '0) && (age == limit - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            age <= '0;
        end else begin
            age <= age + ONE;
        end
    end
endmodule

// File: rtl/tsl_channel.sv
`timescale 1ns/1ps
module tsl_channel
    import tsl_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int MISS_W  = 4,
    parameter int TMO_W   = 16,
    parameter bit HAS_TMO = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              sof,
    input  logic              cls,
    input  logic              rd_rel,
    input  logic              clr,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              valid,
    output logic [TIME_W-1:0] stamp,
    output logic              lost,
    output logic [MISS_W-1:0] miss_cnt
);
    tsl_state_e state, state_nx;
    logic take, expire, hit;

    assign take = sof && cls;
    assign hit  = (state == TSL_FULL) && take && !clr;

    // Next-state logic: clear > release > expire; clear beats take.
    always_comb begin
        state_nx = state;
        unique case (state)
            TSL_EMPTY: if (!clr && take) state_nx = TSL_FULL;
            TSL_FULL:  if (clr || rd_rel || expire) state_nx = TSL_EMPTY;
            default:   state_nx = TSL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TSL_EMPTY;
        else        state <= state_nx;
    end

    // Registered outputs: held stamp and the lost pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
            lost  <= 1'b0;
        end else begin
            if (state == TSL_EMPTY && take && !clr) stamp <= sys_time;
            lost <= (state == TSL_FULL) && expire && !clr && !rd_rel;
        end
    end

    always_comb begin
        valid = (state == TSL_FULL);
    end

    tsl_age_timer #(.TMO_W(TMO_W), .HAS_TMO(HAS_TMO)) u_age (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == TSL_FULL),
        .limit  (tmo_limit),
        .expire (expire)
    );

    tsl_miss_ctr #(.MISS_W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .bump  (hit),
        .cnt   (miss_cnt)
    );
endmodule

// File: rtl/ptp_ts_latch.sv
`timescale 1ns/1ps
module ptp_ts_latch #(
    parameter int TIME_W = 64,
    parameter int MISS_W = 4,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              tx_sof,
    input  logic              tx_mark,
    input  logic              rx_sof,
    input  logic              rx_v2evt,
    input  logic              tx_rd_hi,
    input  logic              rx_rd_hi,
    input  logic              sw_clr,
    input  logic [TMO_W-1:0]  rx_tmo_limit,
    output logic              tx_valid,
    output logic [TIME_W-1:0] tx_stamp,
    output logic              rx_valid,
    output logic [TIME_W-1:0] rx_stamp,
    output logic              rx_lost,
    output logic [MISS_W-1:0] tx_miss_cnt,
    output logic [MISS_W-1:0] rx_miss_cnt
);
    localparam int NCH = 2;   // index 0 = transmit, 1 = receive

    logic [NCH-1:0]             ch_sof, ch_cls, ch_rd, ch_valid, ch_lost;
    logic [NCH-1:0][TIME_W-1:0] ch_stamp;
    logic [NCH-1:0][MISS_W-1:0] ch_miss;

    assign ch_sof = {rx_sof,   tx_sof};
    assign ch_cls = {rx_v2evt, tx_mark};
    assign ch_rd  = {rx_rd_hi, tx_rd_hi};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Only the receive side carries a watchdog.
        tsl_channel #(
            .TIME_W  (TIME_W),
            .MISS_W  (MISS_W),
            .TMO_W   (TMO_W),
            .HAS_TMO (g == 1)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sys_time  (sys_time),
            .sof       (ch_sof[g]),
            .cls       (ch_cls[g]),
            .rd_rel    (ch_rd[g]),
            .clr       (sw_clr),
            .tmo_limit (rx_tmo_limit),
            .valid     (ch_valid[g]),
            .stamp     (ch_stamp[g]),
            .lost      (ch_lost[g]),
            .miss_cnt  (ch_miss[g])
        );
    end

    assign tx_valid    = ch_valid[0];
    assign tx_stamp    = ch_stamp[0];
    assign tx_miss_cnt = ch_miss[0];
    assign rx_valid    = ch_valid[1];
    assign rx_stamp    = ch_stamp[1];
    assign rx_miss_cnt = ch_miss[1];
    assign rx_lost     = ch_lost[1];

    logic unused_tx_lost;
    assign unused_tx_lost = ch_lost[0];
endmodule

// File: rtl/ptp_ts_latch_chk.sv
`timescale 1ns/1ps
module ptp_ts_latch_chk #(
    parameter int TIME_W = 64,
    parameter int MISS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] sys_time,
    input logic              tx_sof,
    input logic              tx_mark,
    input logic              rx_sof,
    input logic              rx_v2evt,
    input logic              tx_rd_hi,
    input logic              rx_rd_hi,
    input logic              sw_clr,
    input logic              tx_valid,
    input logic [TIME_W-1:0] tx_stamp,
    input logic              rx_valid,
    input logic              rx_lost,
    input logic [MISS_W-1:0] tx_miss_cnt,
    input logic [MISS_W-1:0] rx_miss_cnt
);
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && tx_mark && !tx_valid && !sw_clr) |=> (tx_valid && tx_stamp == $past(sys_time)));

    assert_no_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_v2evt && !rx_valid) |=> !rx_valid);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_rd_hi && !sw_clr) |=> (tx_valid && $stable(tx_stamp)));

    assert_miss_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && tx_mark && tx_valid && !sw_clr && tx_miss_cnt != {MISS_W{1'b1}})
        |=> (tx_miss_cnt == $past(tx_miss_cnt) + 1'b1));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_hi && rx_valid) |=> (!rx_valid && !rx_lost));

    assert_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lost |-> (!rx_valid && $past(rx_valid)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (!tx_valid && !rx_valid && tx_miss_cnt == '0 && rx_miss_cnt == '0 && !rx_lost));
endmodule

bind ptp_ts_latch ptp_ts_latch_chk #(.TIME_W(TIME_W), .MISS_W(MISS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_time    (sys_time),
    .tx_sof      (tx_sof),
    .tx_mark     (tx_mark),
    .rx_sof      (rx_sof),
    .rx_v2evt    (rx_v2evt),
    .tx_rd_hi    (tx_rd_hi),
    .rx_rd_hi    (rx_rd_hi),
    .sw_clr      (sw_clr),
    .tx_valid    (tx_valid),
    .tx_stamp    (tx_stamp),
    .rx_valid    (rx_valid),
    .rx_lost     (rx_lost),
    .tx_miss_cnt (tx_miss_cnt),
    .rx_miss_cnt (rx_miss_cnt)
);

// File: tb/ptp_ts_latch_bench.sv
`timescale 1ns/1ps
module ptp_ts_latch_bench;
    localparam int TIME_W = 64;
    localparam int MISS_W = 4;
    localparam int TMO_W  = 16;

    typedef struct {
        bit          txv;
        logic [63:0] txs;
        bit          rxv;
        logic [63:0] rxs;
        bit          lost;
        int          txm;
        int          rxm;
        string       req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TIME_W-1:0] sys_time = '0;
    logic tx_sof = 0, tx_mark = 0, rx_sof = 0, rx_v2evt = 0;
    logic tx_rd_hi = 0, rx_rd_hi = 0, sw_clr = 0;
    logic [TMO_W-1:0]  rx_tmo_limit = '0;
    logic              tx_valid, rx_valid, rx_lost;
    logic [TIME_W-1:0] tx_stamp, rx_stamp;
    logic [MISS_W-1:0] tx_miss_cnt, rx_miss_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    exp_t expq[$];

    // Reference model state
    bit m_txv = 0, m_rxv = 0, m_lost = 0;
    logic [63:0] m_txs = '0, m_rxs = '0;
    int m_txm = 0, m_rxm = 0, m_age = 0;
    logic [63:0] t_now = 64'h1234_0000_0000_0000;
    localparam int SAT = (1 << MISS_W) - 1;

    always #2 clk = ~clk;   // 250 MHz

    ptp_ts_latch #(.TIME_W(TIME_W), .MISS_W(MISS_W), .TMO_W(TMO_W)) u_ptp_ts_latch (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
        .tx_sof(tx_sof), .tx_mark(tx_mark), .rx_sof(rx_sof), .rx_v2evt(rx_v2evt),
        .tx_rd_hi(tx_rd_hi), .rx_rd_hi(rx_rd_hi), .sw_clr(sw_clr),
        .rx_tmo_limit(rx_tmo_limit),
        .tx_valid(tx_valid), .tx_stamp(tx_stamp), .rx_valid(rx_valid), .rx_stamp(rx_stamp),
        .rx_lost(rx_lost), .tx_miss_cnt(tx_miss_cnt), .rx_miss_cnt(rx_miss_cnt)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: drives one cycle of stimulus at the falling edge and queues the
    // state the requirements predict after the next rising edge.
    task automatic step(bit ts, bit tm, bit rs, bit rv, bit tr, bit rr, bit cl, string req);
        exp_t e;
        bit take_t, take_r;
        @(negedge clk);
        t_now = t_now + 64'd7;
        sys_time = t_now;
        tx_sof = ts; tx_mark = tm; rx_sof = rs; rx_v2evt = rv;
        tx_rd_hi = tr; rx_rd_hi = rr; sw_clr = cl;
        take_t = ts && tm;
        take_r = rs && rv;
        if (cl) begin
            m_txv = 0; m_txm = 0;
            m_rxv = 0; m_rxm = 0; m_lost = 0; m_age = 0;
        end else begin
            if (m_txv) begin
                if (take_t && m_txm < SAT) m_txm++;
                if (tr) m_txv = 0;
            end else if (take_t) begin
                m_txv = 1; m_txs = t_now;
            end
            m_lost = 0;
            if (m_rxv) begin
                if (take_r && m_rxm < SAT) m_rxm++;
                if (rr) begin
                    m_rxv = 0; m_age = 0;
                end else if (rx_tmo_limit != 0 && m_age == int'(rx_tmo_limit) - 1) begin
                    m_rxv = 0; m_age = 0; m_lost = 1;
                end else begin
                    m_age++;
                end
            end else if (take_r) begin
                m_rxv = 1; m_rxs = t_now; m_age = 0;
            end
        end
        e.txv = m_txv; e.txs = m_txs; e.rxv = m_rxv; e.rxs = m_rxs;
        e.lost = m_lost; e.txm = m_txm; e.rxm = m_rxm; e.req = req;
        expq.push_back(e);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, req);
    endtask

    // Monitor: compares one queued item per cycle, 1 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(e.req, "tx_valid", 64'(tx_valid), 64'(e.txv));
                if (e.txv) chk(e.req, "tx_stamp", tx_stamp, e.txs);
                chk(e.req, "rx_valid", 64'(rx_valid), 64'(e.rxv));
                if (e.rxv) chk(e.req, "rx_stamp", rx_stamp, e.rxs);
                chk(e.req, "rx_lost", 64'(rx_lost), 64'(e.lost));
                chk(e.req, "tx_miss_cnt", 64'(tx_miss_cnt), 64'(e.txm));
                chk(e.req, "rx_miss_cnt", 64'(rx_miss_cnt), 64'(e.rxm));
            end
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "tx_valid", 64'(tx_valid), 0);
        chk("R1", "rx_valid", 64'(rx_valid), 0);
        chk("R1", "tx_stamp", tx_stamp, 0);
        chk("R1", "rx_stamp", rx_stamp, 0);
        chk("R1", "rx_lost", 64'(rx_lost), 0);
        chk("R1", "tx_miss_cnt", 64'(tx_miss_cnt), 0);
        chk("R1", "rx_miss_cnt", 64'(rx_miss_cnt), 0);
        rst_n = 1'b1;
        idle(2, "R1");

        // R3: strobes without qualifier
        step(1, 0, 1, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 1, 0, 0, 0, "R3");
        idle(1, "R3");

        // R2: transmit capture, R4: held against later strobes
        step(1, 1, 0, 0, 0, 0, 0, "R2");
        idle(2, "R2");
        step(1, 1, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, 0, 0, "R4");
        // R5: release then recapture
        step(0, 0, 0, 0, 1, 0, 0, "R5");
        step(1, 1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 1, 0, "R5"); // reads on empty latches
        idle(1, "R5");

        // R6: watchdog disabled with limit 0
        rx_tmo_limit = '0;
        step(0, 0, 1, 1, 0, 0, 0, "R6");
        idle(20, "R6");
        step(0, 0, 0, 0, 0, 1, 0, "R6");

        // R6: limit 5, no read
        rx_tmo_limit = 16'd5;
        step(0, 0, 1, 1, 0, 0, 0, "R6");
        idle(8, "R6");
        // limit 1
        rx_tmo_limit = 16'd1;
        step(0, 0, 1, 1, 0, 0, 0, "R6");
        idle(3, "R6");

        // R10: read in the expiring cycle
        rx_tmo_limit = 16'd3;
        step(0, 0, 1, 1, 0, 0, 0, "R10");
        idle(2, "R10");
        step(0, 0, 0, 0, 0, 1, 0, "R10");
        idle(2, "R10");

        // R7: transmit ignores the watchdog; R9: receive side unaffected
        rx_tmo_limit = 16'd2;
        step(1, 1, 0, 0, 0, 0, 0, "R7");
        idle(30, "R7");
        // R4: saturate the transmit missed counter, R9: receive stays put
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, 0, 0, "R4");
        // R9: receive capture and miss while transmit held
        rx_tmo_limit = '0;
        step(0, 0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 0, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 0, "R9");
        idle(2, "R9");

        // R8: clear beats read, capture, miss
        step(1, 1, 1, 1, 1, 1, 1, "R8");
        step(1, 1, 1, 1, 0, 0, 1, "R8");
        idle(2, "R8");
        step(1, 1, 1, 1, 0, 0, 0, "R8");
        idle(2, "R8");

        idle(2, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule